// File: doc/BRIEF.md
# Fly-by DMA transfer sequencer

This block is a single-channel bus-master sequencer for direct transfers between an I/O device and memory. A request from the device makes it ask the processor for the bus. Once the processor grants the bus, the block runs fly-by transfers: it drives the paired memory and I/O strobes so that the device and memory exchange data directly, and no data passes through the block.

Only the address goes through the block. The low address byte is on a dedicated output. The high byte is placed on the block's data pins, together with a strobe for an external latch, but only when that latch holds a stale value. After each transfer the address moves by one, up or down, and the word count falls by one. When the count passes below zero, the block signals end of process and gives the bus back.

The start address, count, direction and address step come in as inputs. They are held stable while a run is in progress.

Top module: `flyby_dma_seq`

## Requirements
- R1: While rst_ni is low, hrq_o, aen_o, dack_o, adstb_o, db_oe_o and eop_o are 0, all four active-low strobes are 1, and db_o and addr_lo_o are 0.
- R2: With the sequencer idle and hlda_i low, dreq_i high at a clock edge raises hrq_o from the next cycle. aen_o and every strobe stay inactive until hlda_i has been seen high at a clock edge.
- R3: Each transfer takes two cycles with aen_o high: an address phase, then a transfer phase. After the last transfer of a bus tenure, hrq_o and aen_o are low in the next cycle.
- R4: With dir_mem2io_i = 0 (device to memory), ior_n_o and memw_n_o are low during the transfer phase, and memr_n_o and iow_n_o stay high.
- R5: With dir_mem2io_i = 1 (memory to device), memr_n_o and iow_n_o are low during the transfer phase, and ior_n_o and memw_n_o stay high.
- R6: In an address phase, adstb_o and db_oe_o are high, with db_o = address bits 15:8, exactly when the phase is the first one of a bus tenure or bits 15:8 differ from the last value strobed. Otherwise both are low.
- R7: addr_lo_o carries address bits 7:0 during the address and transfer phases, and 0 when aen_o is low.
- R8: After each transfer the address becomes address+1 when addr_down_i = 0, or address-1 when addr_down_i = 1, modulo 2^16.
- R9: The count falls by one per transfer. A run started with count N makes N+1 transfers, and eop_o is high only during the transfer phase of the last one.
- R10: If dreq_i is low at the edge that ends a transfer phase, the bus is released after that transfer. The next request resumes with the following address and the remaining count.
- R11: start_addr_i and start_cnt_i are captured only when a request is accepted after reset or after an end of process. At any other time their values have no effect.
- R12: dack_o is high during, and only during, each transfer phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_i | input | 1 | Transfer request from the device |
| hlda_i | input | 1 | Bus grant from the processor |
| dir_mem2io_i | input | 1 | 0: device to memory, 1: memory to device |
| addr_down_i | input | 1 | 1: address decrements after each transfer |
| start_addr_i | input | 16 | Start address of a run |
| start_cnt_i | input | 16 | Transfer count minus one |
| hrq_o | output | 1 | Bus request to the processor |
| aen_o | output | 1 | Block owns the address bus |
| dack_o | output | 1 | Transfer acknowledge to the device |
| adstb_o | output | 1 | Strobe for the external high-address latch |
| db_oe_o | output | 1 | Drive enable for db_o |
| db_o | output | 8 | High address byte for the latch |
| addr_lo_o | output | 8 | Low address byte |
| ior_n_o | output | 1 | I/O read strobe, active low |
| iow_n_o | output | 1 | I/O write strobe, active low |
| memr_n_o | output | 1 | Memory read strobe, active low |
| memw_n_o | output | 1 | Memory write strobe, active low |
| eop_o | output | 1 | End of process, last transfer |

## Verification
The assertions check on every cycle that the bus request follows a device request and that the bus is taken only after a grant. They also check that the strobes appear only in pairs matching one direction and only while the bus is owned, that the high-byte latch is refreshed when it goes stale, that each step moves the count and address by exactly one, and that the bus is released right after end of process. Some behaviour only the bench scenarios can show, because it needs a model of the whole run. This covers the full address sequence across page crossings and the 16-bit wrap in both directions, the exact cycles in which the latch strobe fires, the number of transfers for a given count, resumption after a withdrawn request, and that the start values are ignored in the middle of a run.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_ADDR,
    ST_XFER,
    ST_DONE
  } dma_state_e;
endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dreq_i,
  input  logic       hlda_i,
  input  logic       tc_i,
  output dma_state_e state_o
);
  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (dreq_i && !hlda_i) state_d = ST_HOLD;
      ST_HOLD: if (hlda_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_XFER;
      ST_XFER: state_d = (tc_i || !dreq_i) ? ST_DONE : ST_ADDR;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              down_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tc_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= start_addr_i;
      cnt_q  <= start_cnt_i;
    end else if (step_i) begin
      addr_q <= down_i ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign addr_o = addr_q;
  assign tc_o   = (cnt_q == '0);

  assert_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));
  assert_addr_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !down_i) |=> addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1)));
  assert_addr_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && down_i) |=> addr_q == ADDR_W'($past(addr_q) - ADDR_W'(1)));
endmodule

// File: rtl/dma_hi_track.sv
module dma_hi_track #(
  parameter int unsigned HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            capture_i,
  input  logic [HI_W-1:0] addr_hi_i,
  output logic            need_o
);
  logic [HI_W-1:0] hi_q;
  logic            valid_q;

  assign need_o = !valid_q || (hi_q != addr_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end else if (capture_i && need_o) begin
      hi_q    <= addr_hi_i;
      valid_q <= 1'b1;
    end
  end

  // address is stable from address phase into transfer phase
  assert_hi_latched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && need_o) |=> !need_o);
endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LO_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dreq_i,
  input  logic              hlda_i,
  input  logic              dir_mem2io_i,
  input  logic              addr_down_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  output logic              hrq_o,
  output logic              aen_o,
  output logic              dack_o,
  output logic              adstb_o,
  output logic              db_oe_o,
  output logic [ADDR_W-LO_W-1:0] db_o,
  output logic [LO_W-1:0]   addr_lo_o,
  output logic              ior_n_o,
  output logic              iow_n_o,
  output logic              memr_n_o,
  output logic              memw_n_o,
  output logic              eop_o
);
  localparam int unsigned HI_W = ADDR_W - LO_W;

  dma_state_e        state;
  logic              tc, need_hi, load, step, armed_q;
  logic [ADDR_W-1:0] addr;
  logic              in_addr, in_xfer;

  dma_seq_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dreq_i (dreq_i),
    .hlda_i (hlda_i),
    .tc_i   (tc),
    .state_o(state)
  );

  assign in_addr = (state == ST_ADDR);
  assign in_xfer = (state == ST_XFER);
  assign load    = (state == ST_IDLE) && dreq_i && !hlda_i && armed_q;
  assign step    = in_xfer;

  dma_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .step_i      (step),
    .down_i      (addr_down_i),
    .start_addr_i(start_addr_i),
    .start_cnt_i (start_cnt_i),
    .addr_o      (addr),
    .tc_o        (tc)
  );

  dma_hi_track #(.HI_W(HI_W)) u_hi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (state == ST_HOLD),
    .capture_i(in_addr),
    .addr_hi_i(addr[ADDR_W-1:LO_W]),
    .need_o   (need_hi)
  );

  // reload start values only for a fresh run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b1;
    else if (load)       armed_q <= 1'b0;
    else if (step && tc) armed_q <= 1'b1;
  end

  assign hrq_o     = (state == ST_HOLD) || in_addr || in_xfer;
  assign aen_o     = in_addr || in_xfer;
  assign dack_o    = in_xfer;
  assign adstb_o   = in_addr && need_hi;
  assign db_oe_o   = adstb_o;
  assign db_o      = db_oe_o ? addr[ADDR_W-1:LO_W] : '0;
  assign addr_lo_o = aen_o ? addr[LO_W-1:0] : '0;
  assign ior_n_o   = !(in_xfer && !dir_mem2io_i);
  assign memw_n_o  = !(in_xfer && !dir_mem2io_i);
  assign memr_n_o  = !(in_xfer && dir_mem2io_i);
  assign iow_n_o   = !(in_xfer && dir_mem2io_i);
  assign eop_o     = in_xfer && tc;

  assert_hrq_follows_dreq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hrq_o) |-> $past(dreq_i));
  assert_bus_after_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aen_o) |-> $past(hlda_i));
  assert_io2mem_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ior_n_o |-> (!memw_n_o && memr_n_o && iow_n_o));
  assert_mem2io_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !memr_n_o |-> (!iow_n_o && ior_n_o && memw_n_o));
  assert_strobe_owns_bus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ior_n_o || !memr_n_o) |-> (aen_o && dack_o));
  assert_release_after_eop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> (!hrq_o && !aen_o));
  assert_adstb_drives_db_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adstb_o |-> (db_oe_o && aen_o && !dack_o));
  assert_dack_after_addr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> ($past(aen_o) && !$past(dack_o)));
endmodule

// File: tb/tb_flyby_dma_seq.sv
module tb_flyby_dma_seq;
  typedef struct packed {
    logic [15:0] addr;
    logic        hi;
    logic        eop;
    logic        dir;
  } xfer_t;

  logic        clk, rst_n, dreq, hlda, dir, down;
  logic [15:0] cfg_addr, cfg_cnt;
  logic        hrq, aen, dack, adstb, db_oe, eop;
  logic [7:0]  db, addr_lo;
  logic        ior_n, iow_n, memr_n, memw_n;

  int vectors = 0, errors = 0;
  xfer_t exp_q[$];

  // bench model of the run
  logic [15:0] m_addr, m_cnt, m_hi;
  logic        m_armed, m_hi_valid, done;

  flyby_dma_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .dreq_i(dreq), .hlda_i(hlda),
    .dir_mem2io_i(dir), .addr_down_i(down),
    .start_addr_i(cfg_addr), .start_cnt_i(cfg_cnt),
    .hrq_o(hrq), .aen_o(aen), .dack_o(dack), .adstb_o(adstb),
    .db_oe_o(db_oe), .db_o(db), .addr_lo_o(addr_lo),
    .ior_n_o(ior_n), .iow_n_o(iow_n), .memr_n_o(memr_n), .memw_n_o(memw_n),
    .eop_o(eop)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // processor model: grant follows request two cycles later
  initial begin
    logic hq1;
    hq1  = 1'b0;
    hlda = 1'b0;
    forever begin
      @(negedge clk);
      hlda = hq1;
      hq1  = rst_n ? hrq : 1'b0;
    end
  end

  // monitor: capture address phase, compare at transfer phase
  initial begin
    logic ph_stb, ph_db_ok;
    logic [7:0] ph_lo, ph_db;
    xfer_t e;
    ph_stb = 1'b0; ph_lo = '0; ph_db = '0; ph_db_ok = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (aen && !hlda) check(1'b0, "R2", "aen without grant", aen, 0);
        if (!aen) check(ior_n && iow_n && memr_n && memw_n && !dack && addr_lo == 8'h00,
                        "R7", "bus idle outputs", {ior_n, iow_n, memr_n, memw_n, dack}, 5'b11110);
        if (aen && !dack) begin
          ph_stb = adstb; ph_lo = addr_lo; ph_db = db; ph_db_ok = db_oe;
        end
        if (dack) begin
          if (exp_q.size() == 0) check(1'b0, "R12", "unexpected transfer", 1, 0);
          else begin
            e = exp_q.pop_front();
            check(aen, "R12", "dack outside bus tenure", aen, 1);
            check(addr_lo == e.addr[7:0] && ph_lo == e.addr[7:0], "R7 R8 R11", "addr_lo",
                  {ph_lo, addr_lo}, {e.addr[7:0], e.addr[7:0]});
            check(ph_stb == e.hi, "R6", "latch strobe", ph_stb, e.hi);
            if (e.hi) check(ph_db_ok && ph_db == e.addr[15:8], "R6", "high byte", ph_db, e.addr[15:8]);
            if (e.dir) check({ior_n, memw_n, memr_n, iow_n} == 4'b1100, "R5", "strobes",
                             {ior_n, memw_n, memr_n, iow_n}, 4'b1100);
            else       check({ior_n, memw_n, memr_n, iow_n} == 4'b0011, "R4", "strobes",
                             {ior_n, memw_n, memr_n, iow_n}, 4'b0011);
            check(eop == e.eop, "R9", "eop", eop, e.eop);
          end
        end
      end
    end
  end

  // driver: one bus tenure of at most want transfers
  task automatic run_tenure(input int want, input logic d, input logic dn);
    int n, k;
    bit hit_tc;
    xfer_t it;
    dir = d; down = dn;
    if (m_armed) begin m_addr = cfg_addr; m_cnt = cfg_cnt; m_armed = 1'b0; end
    m_hi_valid = 1'b0;
    n = 0; hit_tc = 1'b0;
    while (n < want && !hit_tc) begin
      it.addr = m_addr;
      it.hi   = !m_hi_valid || (m_hi != m_addr[15:8]);
      it.eop  = (m_cnt == 16'h0);
      it.dir  = d;
      exp_q.push_back(it);
      m_hi = m_addr[15:8]; m_hi_valid = 1'b1;
      hit_tc = it.eop;
      m_addr = dn ? m_addr - 16'd1 : m_addr + 16'd1;
      m_cnt  = m_cnt - 16'd1;
      n++;
    end
    if (hit_tc) m_armed = 1'b1;
    while (hlda) @(negedge clk);
    dreq = 1'b1;
    @(negedge clk);
    check(hrq && !aen, "R2", "hold request before grant", {hrq, aen}, 2'b10);
    k = 0;
    while (k < n) begin
      @(negedge clk);
      if (dack) begin
        k++;
        if (k == n) dreq = 1'b0;
      end
    end
    @(negedge clk);
    check(!hrq && !aen, hit_tc ? "R3" : "R10", "bus released", {hrq, aen}, 2'b00);
    check(exp_q.size() == 0, "R9", "transfers outstanding", exp_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    dreq = 1'b0; dir = 1'b0; down = 1'b0;
    cfg_addr = 16'h0; cfg_cnt = 16'h0;
    m_armed = 1'b1; m_hi_valid = 1'b0; m_hi = '0; m_addr = '0; m_cnt = '0;
    done = 1'b0;
    rst_n = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        check(!hrq && !aen && !dack && !adstb && !db_oe && !eop &&
              ior_n && iow_n && memr_n && memw_n && db == 8'h0 && addr_lo == 8'h0,
              "R1", "reset outputs", {hrq, aen, dack, adstb, db_oe, eop}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!hrq, "R2", "no request without dreq", hrq, 0);

        // device to memory, incrementing across a page
        cfg_addr = 16'h12FE; cfg_cnt = 16'd3;
        run_tenure(100, 1'b0, 1'b0);
        // memory to device, decrementing across a page
        cfg_addr = 16'h0201; cfg_cnt = 16'd2;
        run_tenure(100, 1'b1, 1'b1);
        // withdrawn requests, start values changed mid run are ignored
        cfg_addr = 16'h40FF; cfg_cnt = 16'd5;
        run_tenure(2, 1'b0, 1'b0);
        cfg_addr = 16'hAAAA; cfg_cnt = 16'd9;   // R11: not yet captured
        run_tenure(1, 1'b1, 1'b0);
        run_tenure(100, 1'b0, 1'b0);
        // fresh run reloads, wrap through 0xFFFF
        cfg_addr = 16'hFFFF; cfg_cnt = 16'd1;
        run_tenure(100, 1'b0, 1'b0);
        // single transfer run
        cfg_addr = 16'h8000; cfg_cnt = 16'd0;
        run_tenure(100, 1'b1, 1'b1);
        // downward wrap through zero
        cfg_addr = 16'h0001; cfg_cnt = 16'd2;
        run_tenure(100, 1'b0, 1'b1);
        done = 1'b1;
      end
      begin
        repeat (200000) @(negedge clk);
      end
    join_any
    disable fork;
    if (!done) check(1'b0, "R3", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule